// File: doc/BRIEF.md
# Multi-Channel Vectored Interrupt Hub

The hub gathers a bank of level-sensitive interrupt lines, up to 32 of them, and drives one output interrupt line per channel, up to 8 channels. Every channel is a separate controller with its own enable mask. Software can therefore steer each peripheral interrupt to whichever processor owns that channel by enabling the line in only that channel's mask.

Software reaches the hub through a simple memory-mapped target port. A request is accepted in one cycle and its response comes back in the next. Each channel exposes five registers:

- a read-only view of the raw input levels;
- a read-only view of its mask;
- a write-only alias that sets mask bits;
- a write-only alias that clears mask bits;
- a read-only vector register that names the winning input under fixed priority, where the lowest index wins.

Any access that does not land on a legal register, in a legal direction, gets an error response. This lets the hub serve as the default target of an interconnect.

Top module: `vec_irq_hub`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, every channel mask is zero, `irqOut` is zero and `rspValid` is low.
- R2: A request presented with `reqValid` high at a clock edge is answered by `rspValid` high in the following cycle. A cycle with no request is followed by `rspValid` and `rspErr` both low.
- R3: A read at offset `ch*32 + 0` returns the current level of every bit of `irqIn`, with all data bits at or above `NUM_IN` returning zero.
- R4: A read at offset `ch*32 + 4` returns that channel's mask. The masks of different channels are independent.
- R5: A write at offset `ch*32 + 8` ORs the low `NUM_IN` bits of `reqWdata` into that channel's mask.
- R6: A write at offset `ch*32 + 12` clears every bit of that channel's mask that is 1 in `reqWdata`.
- R7: A read at offset `ch*32 + 16` returns, zero-extended, the lowest index i for which `irqIn[i]` and mask bit i of that channel are both 1.
- R8: When no input of the channel is both active and enabled, the vector read returns all ones (`32'hFFFF_FFFF`).
- R9: `irqOut[ch]` is a registered output. It is 1 in the cycle after a clock edge at which the AND of `irqIn` and that channel's mask is nonzero, and 0 otherwise.
- R10: An access with `reqAddr[1:0]` not zero, with a register index (`reqAddr[4:2]`) of 5 to 7, or with a channel field (`reqAddr[ADDR_W-1:5]`) at or above `NUM_CH` gets `rspErr` high and read data zero, and it changes no mask.
- R11: A write to register index 0, 1 or 4, or a read of index 2 or 3, gets `rspErr` high and read data zero, and it changes no mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset within the hub |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspErr | output | 1 | Error response for an illegal access |
| rspRdata | output | DATA_W | Read data, zero on writes and errors |
| irqIn | input | NUM_IN | Level-sensitive interrupt inputs |
| irqOut | output | NUM_CH | One interrupt line per channel |

## Verification
The vector register is driven by a table of input and mask pairs, each chosen to separate one possible fault:
- a lone active line at either end of the range, which catches an inverted priority direction or a truncated index;
- several active lines of which only a higher one is enabled, which shows that masking is applied before the priority encoder;
- lines that are active but fully masked, and no active lines at all, which separate the all-ones "nothing pending" code from index 0 and 31.

Directed sequences then layer set and clear writes to check that OR and AND-NOT accumulate. They check that one channel's writes leave the other masks alone, and that every class of illegal address or direction returns an error and leaves the masks as they were.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  // Channel selector carried in the strobe bundle; wide enough for 8 channels.
  localparam int CH_IDX_W = 3;

  // Register index within a channel window (address bits [4:2]).
  localparam logic [2:0] REG_RAW  = 3'd0;
  localparam logic [2:0] REG_MASK = 3'd1;
  localparam logic [2:0] REG_SET  = 3'd2;
  localparam logic [2:0] REG_CLR  = 3'd3;
  localparam logic [2:0] REG_VEC  = 3'd4;

  // Control-to-datapath strobes for one accepted access.
  typedef struct packed {
    logic                setStb;
    logic                clrStb;
    logic                rdStb;
    logic [2:0]          regIdx;
    logic [CH_IDX_W-1:0] ch;
  } dpStb_t;
endpackage

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output dpStb_t            stb,
  output logic              rspValid,
  output logic              rspErr
);
  localparam int CH_FIELD_W = ADDR_W - 5;

  logic [CH_FIELD_W-1:0] chField;
  logic [2:0]            regField;
  logic                  alignOk;
  logic                  chOk;
  logic                  rdLegal;
  logic                  wrLegal;
  logic                  legal;

  assign chField  = reqAddr[ADDR_W-1:5];
  assign regField = reqAddr[4:2];
  assign alignOk  = (reqAddr[1:0] == 2'b00);
  assign chOk     = (int'(chField) < NUM_CH);
  assign rdLegal  = (regField == REG_RAW) || (regField == REG_MASK) || (regField == REG_VEC);
  assign wrLegal  = (regField == REG_SET) || (regField == REG_CLR);
  assign legal    = alignOk && chOk && (reqWrite ? wrLegal : rdLegal);

  always_comb begin
    stb.setStb = reqValid && legal && reqWrite && (regField == REG_SET);
    stb.clrStb = reqValid && legal && reqWrite && (regField == REG_CLR);
    stb.rdStb  = reqValid && legal && !reqWrite;
    stb.regIdx = regField;
    stb.ch     = CH_IDX_W'(chField);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= reqValid && !legal;
    end
  end

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspErr));

  // R10
  misalign_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[1:0] != 2'b00) |=> rspErr);

  // R11
  ro_write_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr[4:2] == REG_RAW) |=> rspErr);
endmodule

// File: rtl/vec_irq_dp.sv
module vec_irq_dp
  import vec_irq_pkg::*;
#(
  parameter int NUM_IN = 32,
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStb_t            stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_IN-1:0] irqIn,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irqOut
);
  logic [NUM_IN-1:0] maskQ   [NUM_CH];
  logic [NUM_IN-1:0] pend    [NUM_CH];
  logic [DATA_W-1:0] vecVal  [NUM_CH];
  logic [NUM_CH-1:0] anyPend;
  logic [NUM_IN-1:0] wBits;

  assign wBits = wdata[NUM_IN-1:0];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign pend[k]    = irqIn & maskQ[k];
    assign anyPend[k] = |pend[k];

    // Fixed priority: scan downward so the lowest set index is written last.
    always_comb begin
      vecVal[k] = '1;
      for (int i = NUM_IN - 1; i >= 0; i--) begin
        if (pend[k][i]) vecVal[k] = DATA_W'(i);
      end
    end

    // R5
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.setStb && stb.ch == CH_IDX_W'(k)) |=>
        ((maskQ[k] & $past(wBits)) == $past(wBits)));

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.clrStb && stb.ch == CH_IDX_W'(k)) |=> ((maskQ[k] & $past(wBits)) == '0));

    // R11
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(stb.setStb || stb.clrStb) |=> $stable(maskQ[k]));
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_CH; k++) begin
      if (!rstN) begin
        maskQ[k] <= '0;
      end else if (stb.setStb && stb.ch == CH_IDX_W'(k)) begin
        maskQ[k] <= maskQ[k] | wBits;
      end else if (stb.clrStb && stb.ch == CH_IDX_W'(k)) begin
        maskQ[k] <= maskQ[k] & ~wBits;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut <= '0;
      rdata  <= '0;
    end else begin
      irqOut <= anyPend;
      if (stb.rdStb) begin
        case (stb.regIdx)
          REG_RAW:  rdata <= DATA_W'(irqIn);
          REG_MASK: rdata <= DATA_W'(maskQ[stb.ch]);
          REG_VEC:  rdata <= vecVal[stb.ch];
          default:  rdata <= '0;
        endcase
      end else begin
        rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/vec_irq_hub.sv
module vec_irq_hub
  import vec_irq_pkg::*;
#(
  parameter int NUM_IN = 32,
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  input  logic [NUM_IN-1:0] irqIn,
  output logic [NUM_CH-1:0] irqOut
);
  dpStb_t stb;

  vec_irq_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .stb      (stb),
    .rspValid (rspValid),
    .rspErr   (rspErr)
  );

  vec_irq_dp #(.NUM_IN(NUM_IN), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wdata  (reqWdata),
    .irqIn  (irqIn),
    .rdata  (rspRdata),
    .irqOut (irqOut)
  );

  // R10
  err_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspRdata == '0));
endmodule

// File: tb/vec_irq_hub_tb.sv
module vec_irq_hub_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [9:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic        rspErr;
  logic [31:0] rspRdata;
  logic [31:0] irqIn = '0;
  logic [7:0]  irqOut;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vec_irq_hub u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspErr(rspErr), .rspRdata(rspRdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  // {irqIn, mask, expected vector}
  localparam logic [95:0] VEC_TAB [8] = '{
    {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h0000_0001, 32'h0000_0001, 32'h0000_0000},
    {32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_001F},
    {32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_001F},
    {32'h0000_00F0, 32'h0000_00A0, 32'h0000_0005},
    {32'h0001_0100, 32'h0001_0000, 32'h0000_0010},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h0000_0006, 32'hFFFF_FFFE, 32'h0000_0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] regAddr(input int ch, input int idx);
    return 10'(ch * 32 + idx * 4);
  endfunction

  task automatic access(input logic wr, input logic [9:0] addr, input logic [31:0] wd,
                        output logic err, output logic [31:0] rd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    err = rspErr;
    rd  = rspRdata;
    chk("R2 rspValid after request", {31'b0, rspValid}, 32'd1);
  endtask

  task automatic setMask(input int ch, input logic [31:0] val);
    logic e; logic [31:0] d;
    access(1'b1, regAddr(ch, 3), 32'hFFFF_FFFF, e, d);
    access(1'b1, regAddr(ch, 2), val, e, d);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic e;
    logic [31:0] d;

    repeat (3) @(negedge clk);
    // R1: state while reset held
    chk("R1 irqOut in reset", {24'b0, irqOut}, 32'd0);
    chk("R1 rspValid in reset", {31'b0, rspValid}, 32'd0);
    irqIn = 32'hFFFF_FFFF;
    rstN = 1'b1;
    @(negedge clk);
    // R1: masks zero, so no output even with all inputs high
    chk("R1 irqOut after reset", {24'b0, irqOut}, 32'd0);
    chk("R2 idle rspValid", {31'b0, rspValid}, 32'd0);
    access(1'b0, regAddr(0, 1), 32'h0, e, d);
    chk("R1 ch0 mask zero", d, 32'h0);
    access(1'b0, regAddr(7, 1), 32'h0, e, d);
    chk("R1 ch7 mask zero", d, 32'h0);

    // R3: raw levels
    irqIn = 32'hA5A5_0F0F;
    access(1'b0, regAddr(5, 0), 32'h0, e, d);
    chk("R3 raw read", d, 32'hA5A5_0F0F);
    chk("R3 raw no error", {31'b0, e}, 32'd0);
    irqIn = 32'h0;

    // Vector table on channel 2, outputs on channels 2 and 3
    for (int n = 0; n < 8; n++) begin
      logic [31:0] tIn, tMask, tVec;
      {tIn, tMask, tVec} = VEC_TAB[n];
      setMask(2, tMask);
      irqIn = tIn;
      access(1'b0, regAddr(2, 4), 32'h0, e, d);
      if (tVec == 32'hFFFF_FFFF) chk("R8 vector none pending", d, tVec);
      else chk("R7 vector lowest pending", d, tVec);
      chk("R9 irqOut[2] level", {31'b0, irqOut[2]}, {31'b0, ((tIn & tMask) != 0)});
      chk("R9 irqOut[3] unmasked channel", {31'b0, irqOut[3]}, 32'd0);
    end
    setMask(2, 32'h0);
    irqIn = 32'h0;

    // R5 / R6 / R4: accumulate and clear on channel 1, channel 0 untouched
    access(1'b1, regAddr(1, 2), 32'h0000_00F0, e, d);
    chk("R5 set no error", {31'b0, e}, 32'd0);
    access(1'b1, regAddr(1, 2), 32'h0000_0F00, e, d);
    access(1'b0, regAddr(1, 1), 32'h0, e, d);
    chk("R5 set accumulates", d, 32'h0000_0FF0);
    access(1'b1, regAddr(1, 3), 32'h0000_0330, e, d);
    access(1'b0, regAddr(1, 1), 32'h0, e, d);
    chk("R6 clear bits", d, 32'h0000_0CC0);
    access(1'b0, regAddr(0, 1), 32'h0, e, d);
    chk("R4 other channel independent", d, 32'h0);

    // R10: illegal addresses
    access(1'b0, regAddr(0, 5), 32'h0, e, d);
    chk("R10 reg index 5 err", {31'b0, e}, 32'd1);
    chk("R10 reg index 5 data", d, 32'h0);
    access(1'b0, regAddr(1, 7), 32'h0, e, d);
    chk("R10 reg index 7 err", {31'b0, e}, 32'd1);
    access(1'b0, regAddr(8, 1), 32'h0, e, d);
    chk("R10 channel 8 err", {31'b0, e}, 32'd1);
    access(1'b1, 10'h029, 32'hFFFF_FFFF, e, d);
    chk("R10 misaligned err", {31'b0, e}, 32'd1);
    access(1'b1, regAddr(9, 2), 32'hFFFF_FFFF, e, d);
    chk("R10 set on channel 9 err", {31'b0, e}, 32'd1);
    access(1'b0, regAddr(1, 1), 32'h0, e, d);
    chk("R10 mask unchanged", d, 32'h0000_0CC0);

    // R11: wrong direction
    access(1'b1, regAddr(1, 1), 32'h0, e, d);
    chk("R11 write mask reg err", {31'b0, e}, 32'd1);
    access(1'b1, regAddr(1, 0), 32'hFFFF_FFFF, e, d);
    chk("R11 write raw err", {31'b0, e}, 32'd1);
    access(1'b1, regAddr(1, 4), 32'hFFFF_FFFF, e, d);
    chk("R11 write vector err", {31'b0, e}, 32'd1);
    access(1'b0, regAddr(1, 2), 32'h0, e, d);
    chk("R11 read set err", {31'b0, e}, 32'd1);
    chk("R11 read set data", d, 32'h0);
    access(1'b0, regAddr(1, 3), 32'h0, e, d);
    chk("R11 read clear err", {31'b0, e}, 32'd1);
    access(1'b0, regAddr(1, 1), 32'h0, e, d);
    chk("R11 mask unchanged", d, 32'h0000_0CC0);

    // R9: one-cycle registered output timing on channel 6
    setMask(6, 32'h0000_0008);
    @(negedge clk);
    irqIn = 32'h0000_0008;
    chk("R9 irqOut before edge", {31'b0, irqOut[6]}, 32'd0);
    @(negedge clk);
    chk("R9 irqOut after edge", {31'b0, irqOut[6]}, 32'd1);
    chk("R9 irqOut[1] masked line", {31'b0, irqOut[1]}, 32'd0);
    irqIn = 32'h0;
    @(negedge clk);
    chk("R9 irqOut drops", {31'b0, irqOut[6]}, 32'd0);

    // R7 on last channel
    setMask(7, 32'hFFFF_0000);
    irqIn = 32'h00F0_00FF;
    access(1'b0, regAddr(7, 4), 32'h0, e, d);
    chk("R7 ch7 vector", d, 32'h0000_0014);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule